// File: doc/BRIEF.md
# Effective Address Quadrant Qualifier

This block turns a 64-bit effective address into a fully qualified translation context before any table walk starts. The top two address bits pick one of four quadrants. Together with the hypervisor-mode flag, the quadrant decides two things:

- which partition identifier the walk uses: the live partition register or zero;
- which process identifier the walk uses: the live process register or zero.

Some requests cannot be qualified. The block raises a segment fault when the address uses bits in the reserved range, or when a guest touches one of the two quadrants it may not use. A fault on a fetch is reported as an instruction-segment fault. A fault on a load or store is reported as a data-segment fault and latches the faulting address.

A request is a one-cycle strobe with the address, mode, access type and both identifier registers. One cycle later a done pulse appears together with the fault flags and the qualified identifiers. All result outputs hold their values until the next strobe.

Top module: `ea_quadrant_qualifier`

## Requirements
- R1: After reset, done, both fault flags, both identifier outputs, the fault address and the fault code are all zero.
- R2: done is high for exactly the cycle after a cycle with req high and is low otherwise; without req, every result output keeps its value.
- R3: If any of address bits 61 down to 52 (bit 63 is the MSB) is set, the request faults, both identifier outputs are zero, and the quadrant is not considered.
- R4: In hypervisor mode (hv_mode=1), quadrant 0 (ea[63:62]=00) gives partition 0 and the process register. Quadrant 1 (01) gives the partition register and the process register. Quadrant 2 (10) gives the partition register and process 0. Quadrant 3 (11) gives 0 for both.
- R5: In guest mode (hv_mode=0), quadrant 0 gives the partition register and the process register. Quadrant 3 gives the partition register and process 0.
- R6: In guest mode, quadrants 1 and 2 fault, and both identifier outputs are zero.
- R7: A faulting request with access type fetch (acc_type=00) sets iseg_fault, clears dseg_fault, and leaves fault_addr unchanged.
- R8: A faulting request with access type load (01), store (10) or the spare code 11 sets dseg_fault, clears iseg_fault, and loads fault_addr with the request address. A successful request sets neither fault flag and leaves fault_addr unchanged.
- R9: fault_code is zero after every request, faulting or not.
- R10: The identifier inputs are ID_W (32) bits wide. The identifier outputs are OUT_W (64) bits wide, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| hv_mode | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| acc_type | input | 2 | 00 fetch, 01 load, 10 store, 11 treated as data |
| part_reg | input | 32 | Current partition identifier register |
| proc_reg | input | 32 | Current process identifier register |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Segment fault on the last request |
| iseg_fault | output | 1 | Instruction-segment fault |
| dseg_fault | output | 1 | Data-segment fault |
| part_id | output | 64 | Qualified partition identifier |
| proc_id | output | 64 | Qualified process identifier |
| fault_addr | output | 64 | Address of the last data-side fault |
| fault_code | output | 32 | Error code sent with the fault |

## Verification
The directed requests walk all four quadrants in both modes. They use identifier registers with distinct non-zero values, so that each zero-versus-register choice for the partition and the process is seen on its own. All-ones identifiers expose any sign extension or truncation.

Reserved-range faults are driven with only bit 52 set and with only bit 61 set, each in a quadrant that would otherwise be legal. This separates the range check from the quadrant decode. Faults are also driven under each access type, so that a wrong fault-kind choice or a wrong fault-address update shows up.

Idle gaps and back-to-back strobes check that results hold and that done tracks each strobe. A long run of random requests covers mixed sequences.

// File: rtl/ea_quadrant_qualifier.sv
module ea_quadrant_qualifier #(
  parameter int EA_W   = 64,
  parameter int ID_W   = 32,
  parameter int OUT_W  = 64,
  parameter int CODE_W = 32,
  parameter int RSV_HI = 61,
  parameter int RSV_LO = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [EA_W-1:0]   ea,
  input  logic              hv_mode,
  input  logic [1:0]        acc_type,
  input  logic [ID_W-1:0]   part_reg,
  input  logic [ID_W-1:0]   proc_reg,
  output logic              done,
  output logic              fault,
  output logic              iseg_fault,
  output logic              dseg_fault,
  output logic [OUT_W-1:0]  part_id,
  output logic [OUT_W-1:0]  proc_id,
  output logic [EA_W-1:0]   fault_addr,
  output logic [CODE_W-1:0] fault_code
);

  localparam int QHI = EA_W - 1;
  localparam int QLO = EA_W - 2;

  logic [1:0] quad;
  logic       rsv_bad, is_fetch;
  logic       use_part, use_proc, quad_bad, bad;
  logic [OUT_W-1:0] part_x, proc_x;

  assign quad     = ea[QHI:QLO];
  assign rsv_bad  = |ea[RSV_HI:RSV_LO];
  assign is_fetch = (acc_type == 2'b00);
  assign part_x   = OUT_W'(part_reg);
  assign proc_x   = OUT_W'(proc_reg);

  always_comb begin
    use_part = 1'b0;
    use_proc = 1'b0;
    quad_bad = 1'b0;
    if (hv_mode) begin
      unique case (quad)
        2'b00: use_proc = 1'b1;
        2'b01: begin use_part = 1'b1; use_proc = 1'b1; end
        2'b10: use_part = 1'b1;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'b00: begin use_part = 1'b1; use_proc = 1'b1; end
        2'b11: use_part = 1'b1;
        default: quad_bad = 1'b1;
      endcase
    end
  end

  assign bad = rsv_bad | quad_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      iseg_fault <= 1'b0;
      dseg_fault <= 1'b0;
      part_id    <= '0;
      proc_id    <= '0;
      fault_addr <= '0;
      fault_code <= '0;
    end else begin
      done <= req;
      if (req) begin
        fault      <= bad;
        iseg_fault <= bad & is_fetch;
        dseg_fault <= bad & ~is_fetch;
        part_id    <= (!bad && use_part) ? part_x : '0;
        proc_id    <= (!bad && use_proc) ? proc_x : '0;
        fault_code <= '0;
        if (bad && !is_fetch) fault_addr <= ea;
      end
    end
  end

  // R3
  property p_rsv_chk;
    @(posedge clk) disable iff (!rst_n) (req && rsv_bad) |=> (fault && part_id == '0 && proc_id == '0);
  endproperty
  rsv_range_chk: assert property (p_rsv_chk);

  // R6
  property p_guest_chk;
    @(posedge clk) disable iff (!rst_n) (req && !hv_mode && (ea[QHI] ^ ea[QLO])) |=> fault;
  endproperty
  guest_illegal_quad_chk: assert property (p_guest_chk);

  // R4
  property p_hv3_chk;
    @(posedge clk) disable iff (!rst_n) (req && hv_mode && ea[QHI] && ea[QLO]) |=> (part_id == '0 && proc_id == '0);
  endproperty
  hv_quad3_zero_chk: assert property (p_hv3_chk);

  // R7 R8
  property p_kind_chk;
    @(posedge clk) disable iff (!rst_n) done |-> ($onehot0({iseg_fault, dseg_fault}) && (fault == (iseg_fault | dseg_fault)));
  endproperty
  fault_kind_chk: assert property (p_kind_chk);

  // R8
  property p_addr_chk;
    @(posedge clk) disable iff (!rst_n) (req && bad && !is_fetch) |=> (fault_addr == $past(ea));
  endproperty
  data_addr_capture_chk: assert property (p_addr_chk);

  // R2
  property p_hold_chk;
    @(posedge clk) disable iff (!rst_n) !req |=> ($stable(part_id) && $stable(proc_id) && $stable(fault_addr) && !done);
  endproperty
  idle_hold_chk: assert property (p_hold_chk);

  // R10
  property p_ext_chk;
    @(posedge clk) disable iff (!rst_n) done |-> (part_id[OUT_W-1:ID_W] == '0 && proc_id[OUT_W-1:ID_W] == '0);
  endproperty
  zero_ext_chk: assert property (p_ext_chk);

endmodule

// File: tb/ea_quadrant_qualifier_test.sv
module ea_quadrant_qualifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [63:0] ea = '0;
  logic        hv_mode = 1'b0;
  logic [1:0]  acc_type = 2'b00;
  logic [31:0] part_reg = '0, proc_reg = '0;
  logic        done, fault, iseg_fault, dseg_fault;
  logic [63:0] part_id, proc_id, fault_addr;
  logic [31:0] fault_code;

  ea_quadrant_qualifier uut (
    .clk(clk), .rst_n(rst_n), .req(req), .ea(ea), .hv_mode(hv_mode),
    .acc_type(acc_type), .part_reg(part_reg), .proc_reg(proc_reg),
    .done(done), .fault(fault), .iseg_fault(iseg_fault), .dseg_fault(dseg_fault),
    .part_id(part_id), .proc_id(proc_id), .fault_addr(fault_addr), .fault_code(fault_code)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";
  string m_tag = "R1";
  logic        m_done = 0, m_fault = 0, m_iseg = 0, m_dseg = 0;
  logic [63:0] m_part = 0, m_proc = 0, m_addr = 0;

  // Reference model
  always @(posedge clk) begin
    automatic bit illegal;
    automatic logic [63:0] p, q;
    automatic int quad;
    if (!rst_n) begin
      m_done <= 0; m_fault <= 0; m_iseg <= 0; m_dseg <= 0;
      m_part <= 0; m_proc <= 0; m_addr <= 0; m_tag <= "R1";
    end else begin
      m_done <= req;
      if (req) begin
        quad = int'(ea >> 62);
        illegal = ((ea >> 52) & 64'h3FF) != 0;
        p = 0; q = 0;
        if (hv_mode) begin
          if (quad == 0) q = {32'd0, proc_reg};
          else if (quad == 1) begin p = {32'd0, part_reg}; q = {32'd0, proc_reg}; end
          else if (quad == 2) p = {32'd0, part_reg};
        end else begin
          if (quad == 1 || quad == 2) illegal = 1;
          else begin
            p = {32'd0, part_reg};
            if (quad == 0) q = {32'd0, proc_reg};
          end
        end
        if (illegal) begin p = 0; q = 0; end
        m_fault <= illegal;
        m_iseg  <= illegal && acc_type == 2'b00;
        m_dseg  <= illegal && acc_type != 2'b00;
        m_part  <= p;
        m_proc  <= q;
        if (illegal && acc_type != 2'b00) m_addr <= ea;
        m_tag <= tag;
      end
    end
  end

  task automatic cmp(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    cmp("R2 done", 64'(done), 64'(m_done));
    cmp({m_tag, " fault"}, 64'(fault), 64'(m_fault));
    cmp("R7 iseg", 64'(iseg_fault), 64'(m_iseg));
    cmp("R8 dseg", 64'(dseg_fault), 64'(m_dseg));
    cmp({m_tag, " part"}, part_id, m_part);
    cmp({m_tag, " proc"}, proc_id, m_proc);
    cmp("R8 addr", fault_addr, m_addr);
    cmp("R9 code", 64'(fault_code), 64'd0);
  end

  task automatic issue(bit hv, logic [1:0] at, logic [63:0] a, logic [31:0] pr, logic [31:0] pc, string t);
    @(negedge clk);
    hv_mode = hv; acc_type = at; ea = a; part_reg = pr; proc_reg = pc; tag = t; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 hypervisor quadrants
    for (int q = 0; q < 4; q++)
      issue(1, 2'b01, {q[1:0], 62'h0_0012_3456_789A}, 32'h0000_00A5, 32'h0000_5C3D, "R4");
    // R5 guest legal quadrants
    issue(0, 2'b01, 64'h0000_0000_0000_1000, 32'h11, 32'h22, "R5");
    issue(0, 2'b10, 64'hC000_0000_0000_2000, 32'h33, 32'h44, "R5");
    // R6 guest illegal quadrants, all access kinds (R7/R8)
    issue(0, 2'b00, 64'h4000_0000_0000_0010, 32'h1, 32'h2, "R6");
    issue(0, 2'b01, 64'h4000_0000_0000_0020, 32'h1, 32'h2, "R6");
    issue(0, 2'b10, 64'h8000_0000_0000_0030, 32'h1, 32'h2, "R6");
    issue(0, 2'b11, 64'h8000_0000_0000_0040, 32'h1, 32'h2, "R6");
    issue(0, 2'b00, 64'h8000_0000_0000_0050, 32'h1, 32'h2, "R7");
    // R3 reserved range edges
    issue(1, 2'b01, 64'h0010_0000_0000_0000, 32'h7, 32'h8, "R3");
    issue(1, 2'b00, 64'h2000_0000_0000_0000, 32'h7, 32'h8, "R3");
    issue(0, 2'b10, 64'hE000_0000_0000_0000, 32'h7, 32'h8, "R3");
    issue(1, 2'b01, 64'h000F_FFFF_FFFF_FFFF, 32'h7, 32'h8, "R3");
    // R10 all-ones identifiers
    issue(1, 2'b01, 64'h4000_0000_0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    issue(0, 2'b00, 64'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    // R2 idle gap then back-to-back strobes
    repeat (5) @(negedge clk);
    @(negedge clk);
    hv_mode = 1; acc_type = 2'b01; part_reg = 32'h5; proc_reg = 32'h6; tag = "R2";
    ea = 64'h4000_0000_0000_0000; req = 1;
    @(negedge clk);
    ea = 64'h0000_0000_0000_0000;
    @(negedge clk);
    ea = 64'h0100_0000_0000_0000; acc_type = 2'b10;
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    // random mix
    for (int i = 0; i < 400; i++) begin
      automatic logic [63:0] a = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) a[61:52] = '0;
      issue($urandom_range(0, 1), 2'($urandom_range(0, 3)), a, $urandom, $urandom, "R4");
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule